// File: doc/BRIEF.md
# Debug Memory Processor-Access Controller

This block sits beside a CPU's memory request path and services accesses that land in a debug segment whose contents are supplied by an external probe rather than by RAM. It sorts every CPU request into one of three destinations. Ordinary addresses go to the external memory bus. The upper half of the debug segment selects memory-mapped debug registers. The lower half is the probe memory window. A fetch, load or store into the probe window holds the CPU in a stall through its ready signal. The block then latches the access address and direction, keeps store data, and raises a pending flag that the probe can read.

The probe releases the CPU in one of two ways. It can write a control register with the pending bit cleared. It can also issue a fast-transfer operation, which completes only when an access is pending and its address lies in the first 16 bytes of the window. For a pending fetch or load, the word held in the data register is returned to the CPU in the cycle the stall lifts. The CPU request port follows a valid/ready handshake. Once `cpu_valid` is raised, the CPU must keep it high and hold address, kind and store data unchanged until `cpu_ready` is seen high at a clock edge. The block applies back-pressure only to probe-window accesses; every other access completes in the cycle it is presented.

The debug segment spans 0xFFFF_FFFF_FF20_0000 to 0xFFFF_FFFF_FF3F_FFFF, and only the low 21 address bits select a location inside it. Address bit 20 picks the half of the segment. After a debug exception the CPU fetches from 0xFFFF_FFFF_FF20_0200, so each instruction it fetches there is supplied by the probe.

Top module: `dmpa_ctrl`

## Requirements
- R1: A request whose address lies outside the debug segment completes in the cycle it is presented, with `cpu_ready`=1 and `bus_sel`=1.
- R2: A request into the debug register half (segment offset bit 20 = 1) completes at once, with `dregs_sel`=1 and `bus_sel`=0, and raises no pending access.
- R3: A fetch, load or store into the probe window (segment offset bit 20 = 0) holds `cpu_ready` at 0 from its first cycle. From the next cycle onward, control register bit 0 (probe select 0) reads 1.
- R4: Control register bit 1 reads 0 for a pending fetch or load and 1 for a pending store (`cpu_kind` 0 = fetch, 1 = load, 2 = store).
- R5: The address register (probe select 1) holds bits 31:0 of the access address for as long as the access is pending.
- R6: For a pending store, the data register (probe select 2) holds the CPU store data from the cycle after the request.
- R7: A probe write to the control register with bit 0 = 0 while an access is pending causes the following effects from the next cycle. `cpu_ready` is 1, control bit 0 reads 0, and for a fetch or load `cpu_rdata` equals the data register.
- R8: A probe write to the control register with bit 0 = 1 has no effect, and the access stays pending.
- R9: A probe write of 0 to the control register while nothing is pending changes nothing. A later probe-window access still stalls and raises pending.
- R10: `fast_ok` is 1 exactly when an access is pending and its segment offset is below 16.
- R11: A fast operation with `fast_hold`=0 and `fast_ok`=1 completes the access from the next cycle. A pending load then receives `fast_wdata`. With `fast_hold`=1, or with `fast_ok`=0, the access stays pending.
- R12: While a store is pending, `fast_rdata` presents the CPU store data.
- R13: After a released access is accepted, the next sequential fetch into the probe window (for example 0xFFFF_FFFF_FF20_0204 after the debug vector 0xFFFF_FFFF_FF20_0200) stalls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | CPU request valid |
| cpu_ready | output | 1 | Request accepted this cycle; low while stalled |
| cpu_kind | input | 2 | 0 fetch, 1 load, 2 store |
| cpu_addr | input | ADDR_W | Request address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Probe-supplied read data at completion |
| bus_sel | output | 1 | Request is routed to external memory |
| dregs_sel | output | 1 | Request targets the debug register half |
| prb_we | input | 1 | Probe register write strobe |
| prb_sel | input | 2 | 0 control, 1 address, 2 data, 3 reads zero |
| prb_wdata | input | 32 | Probe write data |
| prb_rdata | output | 32 | Probe read data of the selected register |
| fast_valid | input | 1 | Fast-transfer operation strobe |
| fast_hold | input | 1 | 1 = probe status only, do not complete |
| fast_wdata | input | 32 | Word for a pending load (download) |
| fast_ok | output | 1 | A fast operation would succeed now |
| fast_rdata | output | 32 | Data register contents (upload word) |

## Verification
The assertions assume the CPU keeps `cpu_valid` high and its address, kind and store data steady from a request until it is accepted. The check that pending stays set under a fast or set-bit write also assumes the probe does not issue a clearing control write in that same cycle. The bench meets both conditions by changing CPU inputs only right after an accepting edge and by driving a single probe action per cycle, with every strobe dropped after one clock. Under those conditions, a stall may end only after a cycle in which the access was pending, and the latched address cannot move while the access waits.

// File: rtl/dmpa_pkg.sv
package dmpa_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_kind_e;

  typedef enum logic [1:0] {
    PSEL_CTRL = 2'd0,
    PSEL_ADDR = 2'd1,
    PSEL_DATA = 2'd2
  } psel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_DONE = 2'd2
  } pst_e;

  localparam int CTRL_PEND_BIT = 0;
  localparam int CTRL_DIR_BIT  = 1;
  localparam int DATA_W        = 32;
endpackage

// File: rtl/dmpa_decode.sv
module dmpa_decode #(
  parameter int                ADDR_W     = 64,
  parameter logic [ADDR_W-1:0] SEG_BASE   = 64'hFFFF_FFFF_FF20_0000,
  parameter int                SEG_LOG2   = 21,
  parameter int                FAST_BYTES = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_seg,
  output logic              in_win,
  output logic              in_regs,
  output logic              in_fast
);
  localparam logic [SEG_LOG2-1:0] FAST_LIM = SEG_LOG2'(FAST_BYTES);

  // the segment is aligned to its size, so only the bits above the offset compare
  assign in_seg  = (addr[ADDR_W-1:SEG_LOG2] == SEG_BASE[ADDR_W-1:SEG_LOG2]);
  // top offset bit splits probe memory (0) from debug registers (1)
  assign in_win  = in_seg && !addr[SEG_LOG2-1];
  assign in_regs = in_seg &&  addr[SEG_LOG2-1];
  assign in_fast = in_win && (addr[SEG_LOG2-1:0] < FAST_LIM);
endmodule

// File: rtl/dmpa_pacc_fsm.sv
module dmpa_pacc_fsm
  import dmpa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_hit,
  input  logic              req_store,
  input  logic              req_fast,
  input  logic [31:0]       req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              clr_req,
  input  logic              fast_go,
  input  logic [DATA_W-1:0] fast_wdata,
  input  logic              data_we,
  input  logic [DATA_W-1:0] data_wdata,
  output logic              pend,
  output logic              done,
  output logic              dir,
  output logic              fast_ok,
  output logic [31:0]       addr_q,
  output logic [DATA_W-1:0] data_q
);
  pst_e st_q, st_d;
  logic fast_q;
  logic raise;
  logic fast_fire;

  assign pend      = (st_q == ST_PEND);
  assign done      = (st_q == ST_DONE);
  assign fast_ok   = pend && fast_q;
  assign fast_fire = fast_go && fast_ok;
  assign raise     = (st_q == ST_IDLE) && req_hit;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_hit) st_d = ST_PEND;
      ST_PEND: if (clr_req || fast_fire) st_d = ST_DONE;
      ST_DONE: if (req_hit) st_d = ST_IDLE;  // ready is high here, so the CPU is accepted
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      fast_q <= 1'b0;
      dir    <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      st_q <= st_d;
      if (raise) begin
        addr_q <= req_addr;
        dir    <= req_store;
        fast_q <= req_fast;
      end
      if (raise && req_store) begin
        data_q <= req_wdata;
      end else if (fast_fire && !dir) begin
        data_q <= fast_wdata;
      end else if (data_we) begin
        data_q <= data_wdata;
      end
    end
  end
endmodule

// File: rtl/dmpa_probe_regs.sv
module dmpa_probe_regs
  import dmpa_pkg::*;
(
  input  logic              prb_we,
  input  logic [1:0]        prb_sel,
  input  logic [DATA_W-1:0] prb_wdata,
  input  logic              pend,
  input  logic              dir,
  input  logic [31:0]       addr_q,
  input  logic [DATA_W-1:0] data_q,
  output logic              clr_req,
  output logic              data_we,
  output logic [DATA_W-1:0] data_wdata,
  output logic [DATA_W-1:0] prb_rdata
);
  logic [DATA_W-1:0] ctrl_word;

  always_comb begin
    ctrl_word                = '0;
    ctrl_word[CTRL_PEND_BIT] = pend;
    ctrl_word[CTRL_DIR_BIT]  = dir;
  end

  // only a zero in the pending bit is an action; a one is dropped
  assign clr_req    = prb_we && (prb_sel == PSEL_CTRL) && !prb_wdata[CTRL_PEND_BIT];
  assign data_we    = prb_we && (prb_sel == PSEL_DATA);
  assign data_wdata = prb_wdata;

  always_comb begin
    unique case (prb_sel)
      PSEL_CTRL: prb_rdata = ctrl_word;
      PSEL_ADDR: prb_rdata = DATA_W'(addr_q);
      PSEL_DATA: prb_rdata = data_q;
      default:   prb_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dmpa_ctrl.sv
module dmpa_ctrl
  import dmpa_pkg::*;
#(
  parameter int                ADDR_W     = 64,
  parameter logic [ADDR_W-1:0] SEG_BASE   = 64'hFFFF_FFFF_FF20_0000,
  parameter int                SEG_LOG2   = 21,
  parameter int                FAST_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic [1:0]        cpu_kind,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  output logic              bus_sel,
  output logic              dregs_sel,
  input  logic              prb_we,
  input  logic [1:0]        prb_sel,
  input  logic [31:0]       prb_wdata,
  output logic [31:0]       prb_rdata,
  input  logic              fast_valid,
  input  logic              fast_hold,
  input  logic [31:0]       fast_wdata,
  output logic              fast_ok,
  output logic [31:0]       fast_rdata
);
  logic        in_seg, in_win, in_regs, in_fast;
  logic        win_hit;
  logic        pend, done, dir;
  logic        clr_req, data_we;
  logic [31:0] data_wdata;
  logic [31:0] addr_q, data_q;

  dmpa_decode #(
    .ADDR_W(ADDR_W), .SEG_BASE(SEG_BASE), .SEG_LOG2(SEG_LOG2), .FAST_BYTES(FAST_BYTES)
  ) u_dec (
    .addr(cpu_addr), .in_seg(in_seg), .in_win(in_win), .in_regs(in_regs), .in_fast(in_fast)
  );

  assign win_hit = cpu_valid && in_win;

  dmpa_probe_regs u_regs (
    .prb_we(prb_we), .prb_sel(prb_sel), .prb_wdata(prb_wdata),
    .pend(pend), .dir(dir), .addr_q(addr_q), .data_q(data_q),
    .clr_req(clr_req), .data_we(data_we), .data_wdata(data_wdata), .prb_rdata(prb_rdata)
  );

  dmpa_pacc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_hit(win_hit), .req_store(cpu_kind == ACC_STORE), .req_fast(in_fast),
    .req_addr(cpu_addr[31:0]), .req_wdata(cpu_wdata),
    .clr_req(clr_req), .fast_go(fast_valid && !fast_hold), .fast_wdata(fast_wdata),
    .data_we(data_we), .data_wdata(data_wdata),
    .pend(pend), .done(done), .dir(dir), .fast_ok(fast_ok),
    .addr_q(addr_q), .data_q(data_q)
  );

  assign cpu_ready  = !win_hit || done;
  assign cpu_rdata  = (done && !dir) ? data_q : '0;
  assign bus_sel    = cpu_valid && !in_seg;
  assign dregs_sel  = cpu_valid && in_regs;
  assign fast_rdata = data_q;
endmodule

// File: rtl/dmpa_ctrl_chk.sv
module dmpa_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_valid,
  input logic        cpu_ready,
  input logic        in_win,
  input logic        in_seg,
  input logic        pend,
  input logic        done,
  input logic [31:0] addr_q,
  input logic        prb_we,
  input logic [1:0]  prb_sel,
  input logic        prb_wbit0,
  input logic        fast_valid,
  input logic        fast_hold,
  input logic        fast_ok
);
  logic ctrl_clear;
  assign ctrl_clear = prb_we && (prb_sel == 2'd0) && !prb_wbit0;

  // R3
  stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && in_win && cpu_ready |-> $past(pend));

  // R3
  raise_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(cpu_valid && in_win));

  // R1
  ram_nostall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && !in_seg |-> cpu_ready);

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> !pend || $stable(addr_q));

  // R8
  set_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend && prb_we && prb_sel == 2'd0 && prb_wbit0 && !(fast_valid && !fast_hold && fast_ok) |=> pend);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend && !done && !(cpu_valid && in_win) |=> !pend && !done);

  // R11
  fast_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend && fast_valid && (fast_hold || !fast_ok) && !ctrl_clear |=> pend);
endmodule

bind dmpa_ctrl dmpa_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
  .in_win(in_win), .in_seg(in_seg), .pend(pend), .done(done), .addr_q(addr_q),
  .prb_we(prb_we), .prb_sel(prb_sel), .prb_wbit0(prb_wdata[0]),
  .fast_valid(fast_valid), .fast_hold(fast_hold), .fast_ok(fast_ok)
);

// File: tb/dmpa_ctrl_test.sv
module dmpa_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] VEC   = 64'hFFFF_FFFF_FF20_0200;
  localparam logic [63:0] FAREA = 64'hFFFF_FFFF_FF20_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_valid = 0, cpu_ready;
  logic [1:0] cpu_kind = 0;
  logic [63:0] cpu_addr = 0;
  logic [31:0] cpu_wdata = 0, cpu_rdata;
  logic bus_sel, dregs_sel;
  logic prb_we = 0;
  logic [1:0] prb_sel = 0;
  logic [31:0] prb_wdata = 0, prb_rdata;
  logic fast_valid = 0, fast_hold = 0;
  logic [31:0] fast_wdata = 0, fast_rdata;
  logic fast_ok;

  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmpa_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_kind(cpu_kind), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .bus_sel(bus_sel), .dregs_sel(dregs_sel), .prb_we(prb_we), .prb_sel(prb_sel),
    .prb_wdata(prb_wdata), .prb_rdata(prb_rdata), .fast_valid(fast_valid),
    .fast_hold(fast_hold), .fast_wdata(fast_wdata), .fast_ok(fast_ok), .fast_rdata(fast_rdata)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    prb_sel = sel; #1; v = prb_rdata;
  endtask

  task automatic pwr(input logic [1:0] sel, input logic [31:0] d);
    prb_sel = sel; prb_wdata = d; prb_we = 1; tick(); prb_we = 0; #1;
  endtask

  task automatic cpu_go(input logic [1:0] k, input logic [63:0] a, input logic [31:0] d);
    cpu_valid = 1; cpu_kind = k; cpu_addr = a; cpu_wdata = d; #1;
  endtask

  task automatic cpu_accept();
    tick(); cpu_valid = 0; #1;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd0, v); chk("R3 reset ctrl", v, 0);
    chk("R10 reset fast_ok", fast_ok, 0);
    chk("R1 reset ready", cpu_ready, 1);
  endtask

  task automatic t_ram();
    cpu_go(2'd1, 64'h0000_0000_8000_0000, 0);
    chk("R1 ram ready", cpu_ready, 1); chk("R1 ram bus_sel", bus_sel, 1);
    cpu_accept();
    cpu_go(2'd2, 64'hFFFF_FFFF_FF40_0000, 32'h1);
    chk("R1 above-seg ready", cpu_ready, 1); chk("R1 above-seg bus_sel", bus_sel, 1);
    cpu_accept();
  endtask

  task automatic t_dregs();
    logic [31:0] v;
    cpu_go(2'd1, 64'hFFFF_FFFF_FF30_0004, 0);
    chk("R2 dreg ready", cpu_ready, 1); chk("R2 dregs_sel", dregs_sel, 1);
    chk("R2 no bus", bus_sel, 0);
    cpu_accept();
    rd(2'd0, v); chk("R2 no pending", v, 0);
  endtask

  task automatic t_fetch_vec();
    logic [31:0] v;
    cpu_go(2'd0, VEC, 0);
    chk("R3 stall first cycle", cpu_ready, 0);
    tick();
    chk("R3 stall pending", cpu_ready, 0);
    rd(2'd0, v); chk("R3 R4 ctrl fetch", v, 32'h1);
    rd(2'd1, v); chk("R5 addr reg", v, 32'hFF20_0200);
    pwr(2'd2, 32'h1234_5678);
    pwr(2'd0, 32'h1);
    rd(2'd0, v); chk("R8 set ignored", v, 32'h1);
    chk("R8 still stalled", cpu_ready, 0);
    pwr(2'd0, 32'h0);
    chk("R7 released", cpu_ready, 1);
    chk("R7 rdata", cpu_rdata, 32'h1234_5678);
    rd(2'd0, v); chk("R7 pending cleared", v[0], 0);
    tick();
    cpu_addr = VEC + 64'd4; #1;
    chk("R13 next fetch stalls", cpu_ready, 0);
    tick();
    rd(2'd0, v); chk("R13 pending again", v, 32'h1);
    rd(2'd1, v); chk("R13 addr reg", v, 32'hFF20_0204);
    pwr(2'd0, 32'h0);
    cpu_accept();
  endtask

  task automatic t_store();
    logic [31:0] v;
    cpu_go(2'd2, 64'hFFFF_FFFF_FF20_0100, 32'hCAFE_F00D);
    tick();
    rd(2'd0, v); chk("R4 ctrl store dir", v, 32'h3);
    rd(2'd2, v); chk("R6 store data", v, 32'hCAFE_F00D);
    chk("R10 outside fast area", fast_ok, 0);
    pwr(2'd0, 32'h0);
    chk("R7 store released", cpu_ready, 1);
    cpu_accept();
  endtask

  task automatic t_fast_download();
    cpu_go(2'd1, FAREA, 0);
    tick();
    chk("R10 fast_ok load", fast_ok, 1);
    fast_valid = 1; fast_hold = 1; fast_wdata = 32'hDEAD_0001;
    tick(); fast_valid = 0; #1;
    chk("R11 hold keeps stall", cpu_ready, 0);
    chk("R11 hold fast_ok", fast_ok, 1);
    fast_valid = 1; fast_hold = 0; fast_wdata = 32'h0000_BEEF;
    tick(); fast_valid = 0; #1;
    chk("R11 fast released", cpu_ready, 1);
    chk("R11 fast rdata", cpu_rdata, 32'h0000_BEEF);
    chk("R10 fast_ok after", fast_ok, 0);
    cpu_accept();
  endtask

  task automatic t_fast_upload();
    cpu_go(2'd2, FAREA + 64'd8, 32'h0000_0055);
    tick();
    chk("R12 upload word", fast_rdata, 32'h0000_0055);
    chk("R10 fast_ok store", fast_ok, 1);
    fast_valid = 1; fast_hold = 0;
    tick(); fast_valid = 0; #1;
    chk("R11 upload released", cpu_ready, 1);
    cpu_accept();
  endtask

  task automatic t_fast_refused();
    logic [31:0] v;
    fast_valid = 1; fast_hold = 0; #1;
    chk("R10 idle fast_ok", fast_ok, 0);
    tick(); fast_valid = 0; #1;
    cpu_go(2'd1, FAREA + 64'h10, 0);
    tick();
    chk("R10 offset 16 not fast", fast_ok, 0);
    fast_valid = 1;
    tick(); fast_valid = 0; #1;
    rd(2'd0, v); chk("R11 refused stays pending", v, 32'h1);
    chk("R11 refused stall", cpu_ready, 0);
    pwr(2'd0, 32'h0);
    cpu_accept();
  endtask

  task automatic t_idle_zero();
    logic [31:0] v;
    pwr(2'd0, 32'h0);
    rd(2'd0, v); chk("R9 zero write idle", v, 0);
    chk("R9 ready idle", cpu_ready, 1);
    cpu_go(2'd1, 64'hFFFF_FFFF_FF20_0040, 0);
    chk("R9 later access stalls", cpu_ready, 0);
    tick();
    rd(2'd0, v); chk("R9 later access pending", v, 32'h1);
    pwr(2'd0, 32'h0);
    cpu_accept();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1; #1;
    t_reset();
    t_ram();
    t_dregs();
    t_idle_zero();
    t_fetch_vec();
    t_store();
    t_fast_download();
    t_fast_upload();
    t_fast_refused();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule